// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a small bank of binary lock tokens that two independent agents, called the left side and the right side, use to coordinate access to a shared resource. Each side has its own semaphore select, token address, write strobe, output enable, a single write-data bit and a wide read-data bus. The tokens are separate from any data storage. Their values carry no meaning to the hardware; software gives each token its meaning.

A side asks for a token by writing 0 to it. It then reads the token back to learn whether it won: a read of 0 means that side holds the token. It gives the token up by writing 1. Each token keeps one request latch per side. A request from the side that does not hold the token is therefore remembered. When the holder releases, ownership moves to the waiting side in the same clock edge, and that side does not have to ask again. A read captures the token state when the access begins and holds that value for as long as the access lasts.

Top module: `sem_token_bank`

## Requirements
- R1: After reset every token is free, and a read of any token from either side returns all ones.
- R2: A side that writes 0 to a free token becomes its holder. That side then reads all zeros from the token and the other side reads all ones.
- R3: A write from the side that does not hold a token never takes the token and never frees it. The holder keeps reading all zeros.
- R4: When the holder writes 1 and the other side has an outstanding request (it wrote 0 and has not since written 1), ownership passes to the other side at the same clock edge.
- R5: When the holder writes 1 and the other side has no outstanding request, the token becomes free and both sides read all ones. A waiting side that writes 1 before the release withdraws its request.
- R6: When both sides write 0 to the same free token in the same clock cycle, the left side receives it and the right request stays queued.
- R7: A read places the token's single flag bit on every bit of the read bus. While no read is active the read bus is all zeros one cycle later.
- R8: A read value is captured at the clock edge where select and output enable are first both active. It stays unchanged while they stay active, even if ownership changes meanwhile. Read data appears one cycle after the access starts.
- R9: Semaphore access requires the semaphore select active with the RAM enable inactive. With the RAM enable active (which includes the disallowed mix of select, RAM enable and a byte enable) writes have no effect and the read bus stays zero.
- R10: The tokens are independent. An operation on one token address leaves every other token unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_sel | input | 1 | Left semaphore select |
| l_ram_en | input | 1 | Left RAM enable, blocks semaphore access when high |
| l_addr | input | 3 | Left token address |
| l_wr | input | 1 | Left write strobe, one write per cycle held |
| l_oe | input | 1 | Left output enable |
| l_wdata | input | 1 | Left write bit: 0 request, 1 release |
| l_rdata | output | 18 | Left read data, flag replicated |
| r_sem_sel | input | 1 | Right semaphore select |
| r_ram_en | input | 1 | Right RAM enable, blocks semaphore access when high |
| r_addr | input | 3 | Right token address |
| r_wr | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_wdata | input | 1 | Right write bit: 0 request, 1 release |
| r_rdata | output | 18 | Right read data, flag replicated |

## Verification
The checks assume that every input is stable and idle (no select, no strobe) while reset is held. They also assume that a read access that begins is held for at least one full cycle before the bench samples it. The directed tasks drive every input on the falling clock edge, keep each strobe for exactly one rising edge, and leave an idle cycle between back-to-back reads so that each read forms a fresh capture. Requests that must collide are driven on the same falling edge. No scenario has a side write a token while it also reads that same token, because the captured value would then reflect the state before the write.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;
endpackage

// File: rtl/sem_token.sv
module sem_token #(
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic l_wr,
   input  logic l_bit,
   input  logic r_wr,
   input  logic r_bit,
   output logic l_flag,
   output logic r_flag
);
   import sem_pkg::*;

   localparam owner_e TIE_WINNER = TIE_LEFT ? OWN_LEFT : OWN_RIGHT;

   logic   l_req_q, r_req_q;   // active low: 0 means request pending
   logic   l_req_d, r_req_d;
   owner_e own_q, own_d;

   assign l_req_d = l_wr ? l_bit : l_req_q;
   assign r_req_d = r_wr ? r_bit : r_req_q;

   always_comb begin
      own_d = own_q;
      unique case (own_q)
         OWN_NONE: begin
            if (!l_req_d && !r_req_d) own_d = TIE_WINNER;
            else if (!l_req_d)        own_d = OWN_LEFT;
            else if (!r_req_d)        own_d = OWN_RIGHT;
         end
         OWN_LEFT: begin
            if (l_req_d) own_d = r_req_d ? OWN_NONE : OWN_RIGHT;
         end
         OWN_RIGHT: begin
            if (r_req_d) own_d = l_req_d ? OWN_NONE : OWN_LEFT;
         end
         default: own_d = OWN_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         l_req_q <= 1'b1;
         r_req_q <= 1'b1;
         own_q   <= OWN_NONE;
      end else begin
         l_req_q <= l_req_d;
         r_req_q <= r_req_d;
         own_q   <= own_d;
      end
   end

   assign l_flag = (own_q != OWN_LEFT);
   assign r_flag = (own_q != OWN_RIGHT);
endmodule

// File: rtl/sem_port_ctrl.sv
module sem_port_ctrl #(
   parameter int NUM_TOKENS = 8,
   parameter int DATA_W     = 18,
   localparam int SEL_W     = $clog2(NUM_TOKENS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sem_sel,
   input  logic                  ram_en,
   input  logic [SEL_W-1:0]      addr,
   input  logic                  wr,
   input  logic                  oe,
   input  logic [NUM_TOKENS-1:0] flags,
   output logic [NUM_TOKENS-1:0] wr_vec,
   output logic [DATA_W-1:0]     rdata
);
   logic access, rd_act, rd_act_q, cap_q;

   assign access = sem_sel && !ram_en;
   assign rd_act = access && oe;

   for (genvar i = 0; i < NUM_TOKENS; i++) begin : g_wr
      assign wr_vec[i] = access && wr && (addr == SEL_W'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_act_q <= 1'b0;
         cap_q    <= 1'b1;
      end else begin
         rd_act_q <= rd_act;
         if (rd_act && !rd_act_q) cap_q <= flags[addr];
      end
   end

   assign rdata = rd_act_q ? {DATA_W{cap_q}} : '0;
endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank #(
   parameter int NUM_TOKENS = 8,
   parameter int DATA_W     = 18,
   parameter bit TIE_LEFT   = 1'b1,
   localparam int SEL_W     = $clog2(NUM_TOKENS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sem_sel,
   input  logic              l_ram_en,
   input  logic [SEL_W-1:0]  l_addr,
   input  logic              l_wr,
   input  logic              l_oe,
   input  logic              l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_sem_sel,
   input  logic              r_ram_en,
   input  logic [SEL_W-1:0]  r_addr,
   input  logic              r_wr,
   input  logic              r_oe,
   input  logic              r_wdata,
   output logic [DATA_W-1:0] r_rdata
);
   if (NUM_TOKENS < 2 || (1 << SEL_W) != NUM_TOKENS) begin : g_bad_tokens
      $error("NUM_TOKENS must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   logic [NUM_TOKENS-1:0] l_flags, r_flags, l_wr_vec, r_wr_vec;

   sem_port_ctrl #(.NUM_TOKENS(NUM_TOKENS), .DATA_W(DATA_W)) l_port_i (
      .clk(clk), .rst_n(rst_n), .sem_sel(l_sem_sel), .ram_en(l_ram_en),
      .addr(l_addr), .wr(l_wr), .oe(l_oe), .flags(l_flags),
      .wr_vec(l_wr_vec), .rdata(l_rdata));

   sem_port_ctrl #(.NUM_TOKENS(NUM_TOKENS), .DATA_W(DATA_W)) r_port_i (
      .clk(clk), .rst_n(rst_n), .sem_sel(r_sem_sel), .ram_en(r_ram_en),
      .addr(r_addr), .wr(r_wr), .oe(r_oe), .flags(r_flags),
      .wr_vec(r_wr_vec), .rdata(r_rdata));

   for (genvar t = 0; t < NUM_TOKENS; t++) begin : g_tok
      sem_token #(.TIE_LEFT(TIE_LEFT)) tok_i (
         .clk(clk), .rst_n(rst_n),
         .l_wr(l_wr_vec[t]), .l_bit(l_wdata),
         .r_wr(r_wr_vec[t]), .r_bit(r_wdata),
         .l_flag(l_flags[t]), .r_flag(r_flags[t]));
   end
endmodule

// File: rtl/sem_token_bank_chk.sv
module sem_token_bank_chk #(
   parameter int NUM_TOKENS = 8,
   parameter int DATA_W     = 18
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  l_sem_sel,
   input logic                  l_ram_en,
   input logic                  l_wr,
   input logic                  l_oe,
   input logic [DATA_W-1:0]     l_rdata,
   input logic                  r_sem_sel,
   input logic                  r_ram_en,
   input logic                  r_wr,
   input logic                  r_oe,
   input logic [DATA_W-1:0]     r_rdata,
   input logic [NUM_TOKENS-1:0] l_flags,
   input logic [NUM_TOKENS-1:0] r_flags
);
   logic live;
   always_ff @(posedge clk) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   logic l_rd, r_rd, l_wacc, r_wacc;
   assign l_rd   = l_sem_sel && !l_ram_en && l_oe;
   assign r_rd   = r_sem_sel && !r_ram_en && r_oe;
   assign l_wacc = l_sem_sel && !l_ram_en && l_wr;
   assign r_wacc = r_sem_sel && !r_ram_en && r_wr;

   // R2
   excl_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~l_flags) & (~r_flags)) == '0);

   // R3
   l_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !l_wacc) |=> (((~$past(l_flags)) & l_flags) == '0));

   // R3
   r_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !r_wacc) |=> (((~$past(r_flags)) & r_flags) == '0));

   // R7
   l_replicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rdata == '0) || (l_rdata == '1));

   // R7
   r_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !r_rd) |=> (r_rdata == '0));

   // R8
   l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && l_rd && $past(l_rd)) |=> $stable(l_rdata));

   // R8
   r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && r_rd && $past(r_rd)) |=> $stable(r_rdata));
endmodule

bind sem_token_bank sem_token_bank_chk #(.NUM_TOKENS(NUM_TOKENS), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/sem_token_bank_tb_top.sv
`timescale 1ns/1ps
module sem_token_bank_tb_top;
   localparam int DW = 18;
   localparam logic [DW-1:0] ONES  = '1;
   localparam logic [DW-1:0] ZEROS = '0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_sem_sel = 0, l_ram_en = 0, l_wr = 0, l_oe = 0, l_wdata = 0;
   logic r_sem_sel = 0, r_ram_en = 0, r_wr = 0, r_oe = 0, r_wdata = 0;
   logic [2:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_rdata, r_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sem_token_bank dut_i (
      .clk(clk), .rst_n(rst_n),
      .l_sem_sel(l_sem_sel), .l_ram_en(l_ram_en), .l_addr(l_addr), .l_wr(l_wr),
      .l_oe(l_oe), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_sem_sel(r_sem_sel), .r_ram_en(r_ram_en), .r_addr(r_addr), .r_wr(r_wr),
      .r_oe(r_oe), .r_wdata(r_wdata), .r_rdata(r_rdata));

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      l_sem_sel = 0; l_wr = 0; l_oe = 0; l_ram_en = 0;
      r_sem_sel = 0; r_wr = 0; r_oe = 0; r_ram_en = 0;
   endtask

   task automatic do_write(input bit right, input int tok, input bit b);
      @(negedge clk);
      if (right) begin r_sem_sel = 1; r_addr = 3'(tok); r_wr = 1; r_wdata = b; end
      else       begin l_sem_sel = 1; l_addr = 3'(tok); l_wr = 1; l_wdata = b; end
      @(negedge clk);
      idle();
   endtask

   task automatic do_read(input bit right, input int tok, output logic [DW-1:0] val);
      @(negedge clk);
      if (right) begin r_sem_sel = 1; r_addr = 3'(tok); r_oe = 1; end
      else       begin l_sem_sel = 1; l_addr = 3'(tok); l_oe = 1; end
      @(negedge clk);
      val = right ? r_rdata : l_rdata;
      idle();
      @(negedge clk);
   endtask

   task automatic expect_tok(input string req, input int tok, input bit lexp, input bit rexp);
      logic [DW-1:0] v;
      do_read(0, tok, v); chk(req, v, {DW{lexp}});
      do_read(1, tok, v); chk(req, v, {DW{rexp}});
   endtask

   task automatic t_reset();
      for (int t = 0; t < 8; t++) expect_tok("R1 reset free", t, 1, 1);
      chk("R7 idle zero", l_rdata, ZEROS);
      chk("R7 idle zero", r_rdata, ZEROS);
   endtask

   task automatic t_claim();
      do_write(0, 2, 0);
      expect_tok("R2 left claims", 2, 0, 1);
      expect_tok("R10 neighbour untouched", 3, 1, 1);
      do_write(0, 2, 1);
      expect_tok("R5 release free", 2, 1, 1);
      do_write(1, 0, 0);
      expect_tok("R2 right claims", 0, 1, 0);
      do_write(1, 0, 1);
   endtask

   task automatic t_handover();
      do_write(0, 3, 0);
      do_write(1, 3, 1);
      expect_tok("R3 nonowner release ignored", 3, 0, 1);
      do_write(1, 3, 0);
      expect_tok("R3 nonowner request no take", 3, 0, 1);
      do_write(0, 3, 1);
      expect_tok("R4 handover to right", 3, 1, 0);
      do_write(1, 3, 1);
      expect_tok("R5 free after right release", 3, 1, 1);
   endtask

   task automatic t_withdraw();
      do_write(0, 4, 0);
      do_write(1, 4, 0);
      do_write(1, 4, 1);
      do_write(0, 4, 1);
      expect_tok("R5 withdrawn request", 4, 1, 1);
   endtask

   task automatic t_simul();
      @(negedge clk);
      l_sem_sel = 1; l_addr = 3'd5; l_wr = 1; l_wdata = 0;
      r_sem_sel = 1; r_addr = 3'd5; r_wr = 1; r_wdata = 0;
      @(negedge clk);
      idle();
      expect_tok("R6 tie goes left", 5, 0, 1);
      do_write(0, 5, 1);
      expect_tok("R6 queued right served", 5, 1, 0);
      do_write(1, 5, 1);
   endtask

   task automatic t_ram_en();
      logic [DW-1:0] v;
      @(negedge clk);
      l_sem_sel = 1; l_ram_en = 1; l_addr = 3'd6; l_wr = 1; l_wdata = 0;
      @(negedge clk);
      idle();
      expect_tok("R9 blocked write", 6, 1, 1);
      @(negedge clk);
      r_sem_sel = 1; r_ram_en = 1; r_addr = 3'd6; r_oe = 1;
      @(negedge clk);
      v = r_rdata;
      idle();
      chk("R9 blocked read zero", v, ZEROS);
   endtask

   task automatic t_hold();
      logic [DW-1:0] v;
      do_write(0, 1, 0);
      do_write(1, 1, 0);
      @(negedge clk);
      r_sem_sel = 1; r_addr = 3'd1; r_oe = 1;
      @(negedge clk);
      chk("R8 captured at start", r_rdata, ONES);
      l_sem_sel = 1; l_addr = 3'd1; l_wr = 1; l_wdata = 1;
      @(negedge clk);
      l_sem_sel = 0; l_wr = 0;
      chk("R8 held during change", r_rdata, ONES);
      @(negedge clk);
      chk("R8 still held", r_rdata, ONES);
      idle();
      @(negedge clk);
      chk("R7 zero after read ends", r_rdata, ZEROS);
      do_read(1, 1, v);
      chk("R8 fresh capture", v, ZEROS);
      do_write(1, 1, 1);
   endtask

   task automatic t_all_tokens();
      for (int t = 0; t < 8; t++) do_write(t[0], t, 0);
      for (int t = 0; t < 8; t++)
         expect_tok("R10 per token owner", t, t[0], !t[0]);
      for (int t = 0; t < 8; t++) do_write(t[0], t, 1);
      expect_tok("R10 all free again", 7, 1, 1);
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_claim();
      t_handover();
      t_withdraw();
      t_simul();
      t_ram_en();
      t_hold();
      t_all_tokens();
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end
endmodule